// File: doc/BRIEF.md
# Banked Extended-SRAM Access Port

This block sits on a byte-wide host register bus and gives indirect access to an extended battery-backed SRAM. The host cannot address the SRAM directly. It loads a pointer through two byte registers and then moves data through a single data-port register. An optional burst mode advances the pointer after every data-port access, so a whole buffer can be streamed without reloading the pointer.

The 7-bit register space is split by a bank-select bit held in a control byte. A block of general-purpose storage bytes is visible in either bank. The upper half of the space shows 64 more storage bytes in bank 0. In bank 1 the same half shows the pointer, data-port and extended-control registers. The SRAM depth is a parameter that must be a power of two, for example 128, 2048, 4096 or 8192 bytes.

Top module: `nbp_top`

## Requirements
- R1: After reset, rdata, the control byte at 0x0A, the extended-control byte at 0x4A, the pointer and every storage byte are all zero. Bank 0 is selected and burst is off.
- R2: Bit 4 of the byte at 0x0A selects the bank, and 0x0A reads back in either bank. With bit 4 at 0, addresses 0x40–0x7F are 64 plain storage bytes and the pointer is never touched. With bit 4 at 1, that range shows the bank-1 registers.
- R3: Addresses 0x0E–0x3F are 50 storage bytes that read and write the same way in both banks.
- R4: In bank 1, writing 0x50 sets pointer bits 7:0 and writing 0x51 sets pointer bits 15:8. Pointer bits at or above log2(XRAM_BYTES) are dropped. Reads of 0x50 and 0x51 return the stored pointer, with the dropped bits reading 0.
- R5: In bank 1, a write to 0x53 stores the byte at the SRAM location the pointer selects. A read of 0x53 returns that byte.
- R6: When bit 5 of the byte at 0x4A is 1, each data-port access advances the pointer by one after the access. The pointer wraps from XRAM_BYTES-1 to 0. Byte 0x4A reads back as written.
- R7: When bit 5 of 0x4A is 0, data-port accesses leave the pointer unchanged.
- R8: In bank 1, the addresses 0x40–0x7F other than 0x4A, 0x50, 0x51 and 0x53 read 0x00, and writes to them have no effect. The same holds in both banks for 0x00–0x09 and 0x0B–0x0D.
- R9: rdata is registered. It takes the addressed byte at the clock edge where rd_en is sampled high with wr_en low, and holds its value otherwise. When both strobes are high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 7 | Register address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one access per cycle high |
| wr_en | input | 1 | Write strobe, one access per cycle high |
| rdata | output | 8 | Registered read data |

## Verification
Two instances share one bus: one has a 128-byte SRAM, where the high pointer byte is entirely dropped, and one has a 512-byte SRAM, where it is partly kept. Address sweeps over every storage byte are run in both banks. They show whether the bank bit hides or exposes the upper half and leaves the lower block alone. A burst of 512 writes followed by 512 reads, using an arithmetic data pattern, separates the wrap points of the two depths. It also shows any carry error where the pointer crosses from 0xFF to 0x100. Single accesses with burst off, and an access with both strobes high, show whether the pointer moves only when it should.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
    localparam int unsigned AW        = 7;
    localparam int unsigned DW        = 8;
    localparam int unsigned LOW_BYTES = 50;
    localparam int unsigned UP_BYTES  = 64;
    localparam int unsigned BANK_BIT  = 4;
    localparam int unsigned BURST_BIT = 5;

    localparam logic [AW-1:0] A_CTRL   = 7'h0A;
    localparam logic [AW-1:0] A_LOW_LO = 7'h0E;
    localparam logic [AW-1:0] A_LOW_HI = 7'h3F;
    localparam logic [AW-1:0] A_XCTL   = 7'h4A;
    localparam logic [AW-1:0] A_PLO    = 7'h50;
    localparam logic [AW-1:0] A_PHI    = 7'h51;
    localparam logic [AW-1:0] A_PORT   = 7'h53;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STORE,
        SEL_XCTL,
        SEL_PLO,
        SEL_PHI,
        SEL_PORT
    } sel_e;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] xctl;
        logic [DW-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/nbp_decode.sv
module nbp_decode
    import nbp_pkg::*;
#(
    parameter int unsigned IW = 7
) (
    input  logic [AW-1:0] addr,
    input  logic          bank,
    output sel_e          sel,
    output logic [IW-1:0] idx
);
    // Both storage windows are contiguous in index space: 0x0E maps to 0
    // and 0x40 maps to LOW_BYTES.
    logic [AW-1:0] off;
    assign off = addr - A_LOW_LO;

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (addr == A_CTRL) begin
            sel = SEL_CTRL;
        end else if (addr >= A_LOW_LO && addr <= A_LOW_HI) begin
            sel = SEL_STORE;
            idx = IW'(off);
        end else if (addr[AW-1]) begin
            if (!bank) begin
                sel = SEL_STORE;
                idx = IW'(off);
            end else begin
                unique case (addr)
                    A_XCTL:  sel = SEL_XCTL;
                    A_PLO:   sel = SEL_PLO;
                    A_PHI:   sel = SEL_PHI;
                    A_PORT:  sel = SEL_PORT;
                    default: sel = SEL_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/nbp_bytes.sv
module nbp_bytes
    import nbp_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    localparam logic [IW:0] LIMIT = (IW+1)'(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we && ({1'b0, widx} < LIMIT)) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = ({1'b0, ridx} < LIMIT) ? mem_q[ridx] : '0;
endmodule

// File: rtl/nbp_pointer.sv
module nbp_pointer
    import nbp_pkg::*;
#(
    parameter int unsigned XA_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic            step,
    input  logic [DW-1:0]   wdata,
    output logic [XA_W-1:0] ptr,
    output logic [DW-1:0]   lo_byte,
    output logic [DW-1:0]   hi_byte
);
    logic [XA_W-1:0] ptr_d, ptr_q;
    logic [15:0]     wide_q, wide_d;

    assign wide_q = 16'(ptr_q);

    always_comb begin
        wide_d = wide_q;
        if (ld_lo) wide_d[7:0]  = wdata;
        if (ld_hi) wide_d[15:8] = wdata;
        ptr_d = wide_d[XA_W-1:0];
        if (step) ptr_d = ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr     = ptr_q;
    assign lo_byte = wide_q[7:0];
    assign hi_byte = wide_q[15:8];
endmodule

// File: rtl/nbp_top.sv
module nbp_top
    import nbp_pkg::*;
#(
    parameter int unsigned XRAM_BYTES = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [6:0]   addr,
    input  logic [7:0]   wdata,
    input  logic         rd_en,
    input  logic         wr_en,
    output logic [7:0]   rdata
);
    localparam int unsigned XA_W     = (XRAM_BYTES > 1) ? $clog2(XRAM_BYTES) : 1;
    localparam int unsigned ST_DEPTH = LOW_BYTES + UP_BYTES;
    localparam int unsigned ST_IW    = $clog2(ST_DEPTH);

    regs_t r_d, r_q;

    sel_e             sel;
    logic [ST_IW-1:0] st_idx;
    logic [DW-1:0]    st_rd, x_rd, p_lo, p_hi, mux;
    logic [XA_W-1:0]  xptr;
    logic             bank_sel, burst_on, do_rd, do_wr, port_hit;

    assign bank_sel = r_q.ctrl[BANK_BIT];
    assign burst_on = r_q.xctl[BURST_BIT];
    assign do_wr    = wr_en;
    assign do_rd    = rd_en & ~wr_en;
    assign port_hit = (sel == SEL_PORT);

    nbp_decode #(.IW(ST_IW)) u_dec (
        .addr (addr),
        .bank (bank_sel),
        .sel  (sel),
        .idx  (st_idx)
    );

    nbp_bytes #(.DEPTH(ST_DEPTH), .IW(ST_IW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_wr && sel == SEL_STORE),
        .widx  (st_idx),
        .wdata (wdata),
        .ridx  (st_idx),
        .rdata (st_rd)
    );

    nbp_pointer #(.XA_W(XA_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (do_wr && sel == SEL_PLO),
        .ld_hi   (do_wr && sel == SEL_PHI),
        .step    ((do_wr || do_rd) && port_hit && burst_on),
        .wdata   (wdata),
        .ptr     (xptr),
        .lo_byte (p_lo),
        .hi_byte (p_hi)
    );

    nbp_bytes #(.DEPTH(XRAM_BYTES), .IW(XA_W)) u_xram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_wr && port_hit),
        .widx  (xptr),
        .wdata (wdata),
        .ridx  (xptr),
        .rdata (x_rd)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL:  mux = r_q.ctrl;
            SEL_STORE: mux = st_rd;
            SEL_XCTL:  mux = r_q.xctl;
            SEL_PLO:   mux = p_lo;
            SEL_PHI:   mux = p_hi;
            SEL_PORT:  mux = x_rd;
            default:   mux = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (do_wr) begin
            if (sel == SEL_CTRL) r_d.ctrl = wdata;
            if (sel == SEL_XCTL) r_d.xctl = wdata;
        end
        if (do_rd) r_d.rdata = mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;
endmodule

// File: rtl/nbp_chk.sv
module nbp_chk #(
    parameter int unsigned XA_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [6:0]      addr,
    input logic            rd_en,
    input logic            wr_en,
    input logic [7:0]      rdata,
    input logic            bank_sel,
    input logic            burst_on,
    input logic [XA_W-1:0] xptr
);
    logic port_acc, b1_gap;
    assign port_acc = (rd_en || wr_en) && bank_sel && addr == 7'h53;
    assign b1_gap   = bank_sel && addr[6] && addr != 7'h4A && addr != 7'h50 &&
                      addr != 7'h51 && addr != 7'h53;

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> $stable(rdata));

    p_burst_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        port_acc && burst_on |=> (xptr - $past(xptr)) == XA_W'(1));

    p_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        port_acc && !burst_on |=> $stable(xptr));

    p_bank0_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) && !bank_sel |=> $stable(xptr));

    p_gap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && b1_gap |=> rdata == 8'h00);
endmodule

bind nbp_top nbp_chk #(.XA_W(XA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .rdata    (rdata),
    .bank_sel (bank_sel),
    .burst_on (burst_on),
    .xptr     (xptr)
);

// File: tb/nbp_top_tb.sv
module nbp_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] rd_s, rd_w;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    nbp_top #(.XRAM_BYTES(128)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .rdata(rd_s));

    nbp_top #(.XRAM_BYTES(512)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .rdata(rd_w));

    function automatic logic [7:0] gpv(input int a);
        return 8'((a * 5 + 9) & 255);
    endfunction

    function automatic logic [7:0] bv(input int i);
        return 8'((i * 3 + 1) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rdata", rd_s, 8'h00);
        rd(7'h0A); chk("R1 ctrl", rd_s, 8'h00);
        rd(7'h40); chk("R1 store", rd_s, 8'h00);
        rd(7'h53); chk("R1 xram", rd_w, 8'h00);

        // R3/R2: fill every storage byte in bank 0
        for (int a = 14; a < 128; a++) wr(7'(a), gpv(a));
        for (int a = 14; a < 128; a++) begin
            rd(7'(a)); chk("R3 bank0 store", rd_s, gpv(a));
        end

        // bank 1
        wr(7'h0A, 8'h10);
        rd(7'h0A); chk("R2 ctrl readback", rd_w, 8'h10);
        for (int a = 14; a < 64; a++) begin
            rd(7'(a)); chk("R3 bank1 store", rd_w, gpv(a));
        end
        for (int a = 64; a < 128; a++) begin
            if (a != 'h4A && a != 'h50 && a != 'h51 && a != 'h53) begin
                wr(7'(a), 8'hFF);
                rd(7'(a)); chk("R8 bank1 gap", rd_s, 8'h00);
            end
        end
        for (int a = 0; a < 14; a++) begin
            if (a != 'h0A) begin
                wr(7'(a), 8'hFF);
                rd(7'(a)); chk("R8 low gap", rd_w, 8'h00);
            end
        end
        rd(7'h50); chk("R1 ptr zero", rd_w, 8'h00);

        // R2: back to bank 0, upper half intact; 0x50 is storage there
        wr(7'h0A, 8'h00);
        for (int a = 64; a < 128; a++) begin
            rd(7'(a)); chk("R2 bank0 upper", rd_s, gpv(a));
        end
        wr(7'h50, 8'h33);
        rd(7'h50); chk("R2 bank0 0x50 store", rd_s, 8'h33);
        wr(7'h0A, 8'h10);
        rd(7'h50); chk("R2 ptr untouched", rd_w, 8'h00);

        // R4: pointer masking
        wr(7'h50, 8'hFF); wr(7'h51, 8'h03);
        rd(7'h50); chk("R4 lo small", rd_s, 8'h7F); chk("R4 lo wide", rd_w, 8'hFF);
        rd(7'h51); chk("R4 hi small", rd_s, 8'h00); chk("R4 hi wide", rd_w, 8'h01);

        // R7: burst off, pointer holds
        wr(7'h50, 8'h05); wr(7'h51, 8'h00);
        repeat (3) wr(7'h53, 8'hA5);
        rd(7'h53); chk("R5 port small", rd_s, 8'hA5); chk("R5 port wide", rd_w, 8'hA5);
        rd(7'h50); chk("R7 hold small", rd_s, 8'h05); chk("R7 hold wide", rd_w, 8'h05);

        // R6: step across 0xFF / wrap at small depth
        wr(7'h4A, 8'h20);
        rd(7'h4A); chk("R6 xctl readback", rd_s, 8'h20);
        wr(7'h50, 8'hFF);
        wr(7'h53, 8'hC3);
        rd(7'h50); chk("R6 wrap small", rd_s, 8'h00); chk("R6 carry lo wide", rd_w, 8'h00);
        rd(7'h51); chk("R6 carry hi wide", rd_w, 8'h01);

        // R6/R5: burst sweep of 512 bytes
        wr(7'h50, 8'h00); wr(7'h51, 8'h00);
        for (int i = 0; i < 512; i++) wr(7'h53, bv(i));
        rd(7'h50); chk("R6 sweep end small", rd_s, 8'h00); chk("R6 sweep end wide", rd_w, 8'h00);
        rd(7'h51); chk("R6 sweep end hi", rd_w, 8'h00);
        for (int i = 0; i < 512; i++) begin
            rd(7'h53);
            chk("R6 burst read wide", rd_w, bv(i));
            chk("R6 burst read small", rd_s, bv(384 + (i % 128)));
        end

        // R5/R7: random access with burst off
        wr(7'h4A, 8'h00);
        wr(7'h51, 8'h01); wr(7'h50, 8'h10);
        rd(7'h53); chk("R5 wide 0x110", rd_w, bv(272)); chk("R5 small 0x10", rd_s, bv(400));
        rd(7'h53); chk("R7 reread wide", rd_w, bv(272));

        // R9: both strobes, and hold while idle
        wr(7'h4A, 8'h20);
        rd(7'h0A); chk("R9 read ctrl", rd_s, 8'h10);
        @(negedge clk);
        addr = 7'h53; wdata = 8'h77; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9 both strobes hold", rd_s, 8'h10);
        repeat (3) @(negedge clk);
        chk("R9 idle hold", rd_w, 8'h10);
        rd(7'h50); chk("R9 single step small", rd_s, 8'h11); chk("R9 single step wide", rd_w, 8'h11);
        wr(7'h4A, 8'h00); wr(7'h50, 8'h10);
        rd(7'h53); chk("R9 write landed", rd_s, 8'h77); chk("R9 write landed wide", rd_w, 8'h77);

        done = 1'b1;
        finish_run();
    end
endmodule